// File: doc/BRIEF.md
# Single-Cycle Nine-Instruction Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. Each cycle it fetches a word from its own instruction array at the program counter and decodes it. It reads two operands from a 32-entry register file and runs them through an ALU. A load, or a stored result, goes back through the data array. At the rising edge the register file, the data array and the program counter all update together. The core knows nine instructions: word load and store, the five register-to-register operations add, subtract, AND, OR and signed set-less-than, a branch on equal, and an absolute jump.

The instruction and data arrays are separate and live inside the block. While the core is held in reset, a load port writes words into either array, so a program and its starting data can be placed before execution begins. A debug port reads any register at any time without disturbing execution. The current program counter is also brought out, so the instruction flow can be followed cycle by cycle.

Top module: `onecycle_core`

## Requirements
- R1: Synchronous reset, sampled at the rising edge, sets the program counter to 0 and clears every register. While reset is high, no register or data word is written by instructions.
- R2: After any instruction that is not a taken branch and not a jump, the program counter becomes PC+4. This covers unknown opcodes, which otherwise act as no-ops.
- R3: An R-type word (opcode 0x00, source registers in bits 25:21 and 20:16, destination in bits 15:11, function code in bits 5:0) writes its result to the destination register. The function codes are 0x20 add, 0x22 subtract (first minus second), 0x24 AND, 0x25 OR and 0x2A set-less-than. Set-less-than compares as signed numbers and gives 1 or 0.
- R4: Register 0 always reads as zero, and a write to it leaves it zero.
- R5: Load (opcode 0x23) and store (opcode 0x2B) use the address base register (bits 25:21) plus the sign-extended 16-bit offset (bits 15:0). The word index is taken from address bits [N+1:2]. A load writes the word to register bits 20:16, and a store writes that register's value to the data array.
- R6: Store and branch words never write the register file, whatever their bits 15:11 hold.
- R7: Branch-on-equal (opcode 0x04) subtracts its two registers in the ALU. When the ALU zero flag is 1, the next PC is PC+4 plus the sign-extended offset shifted left by 2. Otherwise the next PC is PC+4.
- R8: Jump (opcode 0x02) sets the next PC to the upper 4 bits of PC+4, then bits 25:0 of the word, then two zero bits.
- R9: When load enable is high at a rising edge, the load data is written to the word at load address bits [N+1:2]. The select input picks the target: 1 for the data array, 0 for the instruction array.
- R10: The debug port returns the selected register's current value combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Write one word through the load port |
| load_dmem | input | 1 | Load target: 1 data array, 0 instruction array |
| load_addr | input | 32 | Byte address of the loaded word |
| load_data | input | 32 | Word to load |
| dbg_sel | input | 5 | Register number to observe |
| dbg_val | output | 32 | Value of the observed register |
| pc_out | output | 32 | Current program counter |

## Verification
The core runs one preloaded program. Its straight-line section uses operands chosen so that each of the five ALU operations gives a value no other operation would give. It includes a negative value, so a signed set-less-than and an unsigned one differ, and a write aimed at register 0. The memory section uses a negative base register and a negative offset. One store has offset bits that name register 31, so a store that wrongly wrote the register file would show up there. The control section follows the program counter every cycle through a not-taken branch, a forward taken branch, a jump, an unknown opcode and a backward branch to itself. A second reset in the middle of the run must bring the counter back to zero.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_AND = 4'h0,
    ALU_OR  = 4'h1,
    ALU_ADD = 4'h2,
    ALU_SUB = 4'h6,
    ALU_SLT = 4'h7
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    src_imm;
    logic    mem_we;
    logic    mem_rd;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] alu_eval(input alu_op_e op,
                                           input logic [31:0] a,
                                           input logic [31:0] b);
    case (op)
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      ALU_SLT: return {31'b0, ($signed(a) < $signed(b))};
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] branch_target(input logic [31:0] pc4,
                                                input logic [15:0] off);
    return pc4 + {sext16(off)[29:0], 2'b00};
  endfunction

  function automatic logic [31:0] jump_target(input logic [31:0] pc4,
                                              input logic [25:0] idx);
    return {pc4[31:28], idx, 2'b00};
  endfunction

endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{reg_we: 1'b0, dst_rd: 1'b0, src_imm: 1'b0, mem_we: 1'b0,
             mem_rd: 1'b0, branch: 1'b0, jump: 1'b0, alu_op: ALU_ADD};
    case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_LW: begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OP_SW: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_J:    ctrl.jump = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  output logic [W-1:0]  rd3,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
  assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

  // R4: a write aimed at register 0 leaves it reading zero
  a_r4_zero_kept: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0) |=> (regs[0] == '0));

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
(
  input  alu_op_e     op,
  input  logic [31:0] a,
  input  logic [31:0] b,
  output logic [31:0] y,
  output logic        zero
);

  assign y    = alu_eval(op, a, b);
  assign zero = (y == 32'd0);

endmodule

// File: rtl/onecycle_core.sv
module onecycle_core
  import core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load_en,
  input  logic        load_dmem,
  input  logic [31:0] load_addr,
  input  logic [31:0] load_data,
  input  logic [4:0]  dbg_sel,
  output logic [31:0] dbg_val,
  output logic [31:0] pc_out
);

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  logic [31:0] pc, pc4, pc_next, br_tgt, j_tgt;
  logic [31:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, mem_word, wb_val;
  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd, wa;
  logic [15:0] imm;
  logic [25:0] jidx;
  logic        alu_zero, rf_we;
  ctrl_t       ctrl;

  // named events for the assertions
  logic ev_taken, ev_jump, ev_seq;

  assign instr  = imem[pc[IAW+1:2]];
  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign funct  = instr[5:0];
  assign imm    = instr[15:0];
  assign jidx   = instr[25:0];

  core_decode u_dec (.opcode(opcode), .funct(funct), .ctrl(ctrl));

  assign rf_we  = ctrl.reg_we && !rst;
  assign wa     = ctrl.dst_rd ? rd : rt;

  core_regfile #(.NREG(32), .W(32)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(rs), .ra2(rt), .ra3(dbg_sel),
    .rd1(rs_val), .rd2(rt_val), .rd3(dbg_val),
    .we(rf_we), .wa(wa), .wd(wb_val)
  );

  assign imm_ext = sext16(imm);
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_val;

  core_alu u_alu (.op(ctrl.alu_op), .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero));

  assign mem_word = dmem[alu_y[DAW+1:2]];
  assign wb_val   = ctrl.mem_rd ? mem_word : alu_y;

  assign pc4      = pc + 32'd4;
  assign br_tgt   = branch_target(pc4, imm);
  assign j_tgt    = jump_target(pc4, jidx);
  assign ev_taken = ctrl.branch && alu_zero;
  assign ev_jump  = ctrl.jump;
  assign ev_seq   = !ev_taken && !ev_jump;
  assign pc_next  = ev_jump ? j_tgt : (ev_taken ? br_tgt : pc4);

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      if (load_dmem) dmem[load_addr[DAW+1:2]] <= load_data;
      else           imem[load_addr[IAW+1:2]] <= load_data;
    end else if (!rst && ctrl.mem_we) begin
      dmem[alu_y[DAW+1:2]] <= rt_val;
    end
  end

  assign pc_out = pc;

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], pc[1:0], pc[31:IAW+2], alu_y[1:0], alu_y[31:DAW+2],
                         load_addr[1:0], load_addr[31:2]};

  // R1: reset forces the counter to zero
  a_r1_pc_reset: assert property (@(posedge clk) rst |=> (pc == 32'd0));

  // R2: fall-through advances by one word
  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    ev_seq |=> (pc == $past(pc) + 32'd4));

  // R3: set-less-than yields only 0 or 1
  a_r3_slt_bool: assert property (@(posedge clk) disable iff (rst)
    (ctrl.alu_op == ALU_SLT) |-> (alu_y[31:1] == 31'd0));

  // R6: stores and branches leave the register file alone
  a_r6_no_rf_write: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_SW || opcode == OP_BEQ) |-> !rf_we);

  // R7: taken branch lands on PC+4 plus scaled offset
  a_r7_branch_dest: assert property (@(posedge clk) disable iff (rst)
    ev_taken |=> (pc == $past(pc) + 32'd4 + ($past(imm_ext) << 2)));

  // R8: jump keeps the top nibble of PC+4
  a_r8_jump_region: assert property (@(posedge clk) disable iff (rst)
    ev_jump |=> (pc[31:28] == $past(pc4[31:28]) && pc[27:0] == {$past(jidx), 2'b00}));

endmodule

// File: tb/test_onecycle_core.sv
`timescale 1ns/1ps
module test_onecycle_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic        load_dmem = 1'b0;
  logic [31:0] load_addr = '0;
  logic [31:0] load_data = '0;
  logic [4:0]  dbg_sel = '0;
  logic [31:0] dbg_val, pc_out;

  int checks = 0;
  int errors = 0;
  logic run_chk = 1'b0;
  logic [31:0] exp_q [$];

  always #2.5 clk = ~clk;

  onecycle_core i_onecycle_core (
    .clk(clk), .rst(rst), .load_en(load_en), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data),
    .dbg_sel(dbg_sel), .dbg_val(dbg_val), .pc_out(pc_out)
  );

  function automatic logic [31:0] enc_r(input int s, input int t, input int d, input logic [5:0] fn);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input logic [15:0] im);
    return {op, 5'(s), 5'(t), im};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic tgt, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    load_en = 1'b1; load_dmem = tgt; load_addr = a; load_data = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic reg_is(input string req, input int r, input logic [31:0] exp);
    dbg_sel = 5'(r);
    #0.5;
    chk(req, dbg_val, exp);
  endtask

  // monitor: pops expected PCs and compares one per cycle
  always @(posedge clk) begin
    #1;
    if (run_chk && exp_q.size() > 0) begin
      logic [31:0] e;
      e = exp_q.pop_front();
      chk("R2/R7/R8 pc flow", pc_out, e);
    end
  end

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pc in reset", pc_out, 32'd0);
    reg_is("R1 regs cleared", 1, 32'd0);

    // R9: preload data then program
    put(1'b1, 32'h0, 32'd7);
    put(1'b1, 32'h4, 32'd5);
    put(1'b1, 32'h8, 32'hFFFF_FFF0);
    put(1'b0, 32'h00, enc_i(6'h23, 0, 1, 16'd0));
    put(1'b0, 32'h04, enc_i(6'h23, 0, 2, 16'd4));
    put(1'b0, 32'h08, enc_i(6'h23, 0, 3, 16'd8));
    put(1'b0, 32'h0C, enc_r(1, 2, 4, 6'h20));
    put(1'b0, 32'h10, enc_r(2, 1, 5, 6'h22));
    put(1'b0, 32'h14, enc_r(1, 2, 6, 6'h24));
    put(1'b0, 32'h18, enc_r(1, 3, 7, 6'h25));
    put(1'b0, 32'h1C, enc_r(3, 1, 8, 6'h2A));
    put(1'b0, 32'h20, enc_r(1, 3, 9, 6'h2A));
    put(1'b0, 32'h24, enc_r(1, 2, 0, 6'h20));
    put(1'b0, 32'h28, enc_i(6'h2B, 0, 4, 16'd16));
    put(1'b0, 32'h2C, enc_i(6'h23, 0, 10, 16'd16));
    put(1'b0, 32'h30, enc_i(6'h2B, 3, 5, 16'd36));
    put(1'b0, 32'h34, enc_i(6'h23, 0, 11, 16'd20));
    put(1'b0, 32'h38, enc_i(6'h04, 1, 2, 16'd5));
    put(1'b0, 32'h3C, enc_i(6'h04, 4, 10, 16'd2));
    put(1'b0, 32'h40, enc_r(1, 1, 12, 6'h20));
    put(1'b0, 32'h44, enc_r(1, 1, 12, 6'h20));
    put(1'b0, 32'h48, {6'h02, 26'h15});
    put(1'b0, 32'h4C, enc_r(1, 1, 13, 6'h20));
    put(1'b0, 32'h50, enc_r(1, 1, 13, 6'h20));
    put(1'b0, 32'h54, 32'hFC00_0000);
    put(1'b0, 32'h58, enc_i(6'h2B, 4, 2, 16'hFFFC));
    put(1'b0, 32'h5C, enc_i(6'h23, 0, 14, 16'd8));
    put(1'b0, 32'h60, enc_i(6'h04, 0, 0, 16'hFFFF));
    chk("R1 pc held during load", pc_out, 32'd0);

    // driver: expected PC after every executed cycle
    for (int a = 4; a <= 'h3C; a += 4) exp_q.push_back(32'(a));
    exp_q.push_back(32'h48);  // R7 forward taken
    exp_q.push_back(32'h54);  // R8 jump
    exp_q.push_back(32'h58);  // R2 unknown opcode advances
    exp_q.push_back(32'h5C);
    exp_q.push_back(32'h60);
    exp_q.push_back(32'h60);  // R7 backward to self
    exp_q.push_back(32'h60);

    @(negedge clk);
    rst = 1'b0;
    run_chk = 1'b1;
    repeat (24) @(negedge clk);
    run_chk = 1'b0;
    chk("R2/R7/R8 queue drained", 32'(exp_q.size()), 32'd0);

    reg_is("R5 load word", 1, 32'd7);
    reg_is("R5 load word", 3, 32'hFFFF_FFF0);
    reg_is("R3 add", 4, 32'd12);
    reg_is("R3 sub", 5, 32'hFFFF_FFFE);
    reg_is("R3 and", 6, 32'd5);
    reg_is("R3 or", 7, 32'hFFFF_FFF7);
    reg_is("R3 slt signed true", 8, 32'd1);
    reg_is("R3 slt signed false", 9, 32'd0);
    reg_is("R4 reg zero write ignored", 0, 32'd0);
    reg_is("R5 store then load", 10, 32'd12);
    reg_is("R5 negative base store", 11, 32'hFFFF_FFFE);
    reg_is("R5 negative offset store", 14, 32'd5);
    reg_is("R6 store leaves r31", 31, 32'd0);
    reg_is("R7 skipped by branch", 12, 32'd0);
    reg_is("R8 skipped by jump", 13, 32'd0);
    reg_is("R10 debug read r2", 2, 32'd5);

    // R1: mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 pc after mid-run reset", pc_out, 32'd0);
    reg_is("R1 regs cleared after reset", 4, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule